// File: doc/BRIEF.md
# Resistive CAM access sequencer

This block runs the control lines of a small array of non-volatile resistive content-addressable cells. Each cell holds a bit and its complement in two resistive elements, and the cells of a row form a series match chain. Requests arrive on one valid/ready port, each either a write or a search. A write carries a row address and a data word. A search carries only a search word. The block turns each request into a timed sequence on the array lines: word select, search select, the VL drive level, match-line precharge and the shared data/search bus. A search ends with one registered match vector.

Each phase length is a parameter counted in clock cycles. There is one bus for data and search bits, so the block handles one operation at a time. Ready stays low until the sequencer is back in its idle state.

Every state of the controller and every way out of it:

- `ST_IDLE`: ready is high. An accepted write goes to `ST_WSETUP` and an accepted search goes to `ST_PCHG`.
- `ST_WSETUP`: select the row and put the data on the bus, with VL off, for `SETUP_CYC` cycles. Then go to `ST_WPULSE`.
- `ST_WPULSE`: drive VL at the half level with the row still selected, for `WR_CYC` cycles. Then go to `ST_WREL`.
- `ST_WREL`: every line is inactive for one cycle. Then go to `ST_IDLE`.
- `ST_PCHG`: precharge the match lines with the search word on the bus, for `PCHG_CYC` cycles. Then go to `ST_SSEL`.
- `ST_SSEL`: search select is high and VL is off, for `SEL_CYC` cycles. Then go to `ST_EVAL`.
- `ST_EVAL`: search select is high and VL is at the full level, for `RD_CYC` cycles. The match lines are captured on the last cycle. Then go to `ST_DONE`.
- `ST_DONE`: the response is valid for one cycle and every line is inactive. Then go to `ST_IDLE`.

Top module: `rcam_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and the outputs are at rest: `rsp_valid`=0, `rsp_match`=0, `wsel`=0, `ssel`=0, `pchg`=0, `bus_oe`=0 and `vl_lvl`=00.
- R2: A write to row r drives `wsel` to the one-hot value 1<<r. This lasts for `SETUP_CYC` cycles with `vl_lvl`=00, then for exactly `WR_CYC` cycles with `vl_lvl`=01. Throughout the write, `ssel` and `pchg` stay 0.
- R3: During a search, `wsel` is 0 in every cycle, so select and search never share the bus.
- R4: A search runs its phases in a fixed order. First `pchg`=1 for `PCHG_CYC` cycles, with `ssel`=0 and `vl_lvl`=00. Next `ssel`=1 with `vl_lvl`=00 for `SEL_CYC` cycles. Last `ssel`=1 with `vl_lvl`=10 for `RD_CYC` cycles. `pchg` and `ssel` are never high together.
- R5: A match line is active low. Bit r of `rsp_match` is 1 exactly when `ml_n[r]` is 0 on the last full-level cycle. With the array modelled, this sets the bits of the rows whose stored word equals the search word.
- R6: `rsp_valid` is 1 for exactly one cycle. That cycle comes `PCHG_CYC+SEL_CYC+RD_CYC+1` cycles after the accepting edge. `rsp_match` keeps its value until the next search response.
- R7: `req_ready` is 1 only in idle. A request held valid during an operation is accepted once, on the first edge after ready returns.
- R8: Every operation ends with one cycle in which all array lines are inactive: `wsel`=0, `ssel`=0, `pchg`=0, `bus_oe`=0 and `vl_lvl`=00.
- R9: `vl_lvl` never takes the value 11. The value 01 appears only while a row is selected, and 10 only while `ssel`=1.
- R10: While an operation drives the bus, `bus_oe`=1 and `bus_d` equals the word accepted with the request, even if `req_data` changes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = search |
| req_row | input | ROW_W | Target row of a write |
| req_data | input | WORD_W | Data word of a write or search word |
| rsp_valid | output | 1 | One-cycle search result strobe |
| rsp_match | output | ROWS | Per-row match result, 1 = row matched |
| wsel | output | ROWS | One-hot word select lines |
| ssel | output | 1 | Search select, common to all rows |
| vl_lvl | output | 2 | VL drive: 00 off, 01 half, 10 full |
| pchg | output | 1 | Match-line precharge |
| bus_oe | output | 1 | Shared data/search bus driven |
| bus_d | output | WORD_W | Shared data/search bus value |
| ml_n | input | ROWS | Match lines from the array, low = match |

## Verification
The hard case is a request held valid while the sequencer is busy. It must be taken exactly once when ready returns, and the next operation must use the newly presented word rather than the one on the bus. The bench reaches this case by leaving valid high with a write request that it sets on the cycle right after a search is accepted. It then proves that only one write took place by sweeping searches over the array. Other sweeps of every search word against arrays holding distinct, duplicate and overwritten rows cover the zero-hit, single-hit and multi-hit match vectors.

// File: rtl/rcam_pkg.sv
package rcam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WREL,
        ST_PCHG,
        ST_SSEL,
        ST_EVAL,
        ST_DONE
    } rseq_state_e;

    typedef enum logic [1:0] {
        VL_OFF  = 2'b00,
        VL_HALF = 2'b01,
        VL_FULL = 2'b10
    } vl_lvl_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rcam_phase_timer.sv
module rcam_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit) else $error("timer past phase length"); // R6

endmodule

// File: rtl/rcam_fsm.sv
module rcam_fsm
    import rcam_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int SETUP_CYC = 1,
    parameter int WR_CYC    = 22,
    parameter int PCHG_CYC  = 2,
    parameter int SEL_CYC   = 1,
    parameter int RD_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_restart,
    output logic [CNT_W-1:0] phase_len,
    output logic             req_fire,
    output logic             ready,
    output logic             wsel_en,
    output logic             ssel,
    output logic             pchg,
    output logic             bus_oe,
    output logic [1:0]       vl,
    output logic             capture,
    output logic             rsp_valid
);
    rseq_state_e state_q, state_d;

    assign req_fire    = req_valid && ready;
    assign tmr_restart = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_fire) state_d = req_write ? ST_WSETUP : ST_PCHG;
            ST_WSETUP: if (tmr_done) state_d = ST_WPULSE;
            ST_WPULSE: if (tmr_done) state_d = ST_WREL;
            ST_WREL:   state_d = ST_IDLE;
            ST_PCHG:   if (tmr_done) state_d = ST_SSEL;
            ST_SSEL:   if (tmr_done) state_d = ST_EVAL;
            ST_EVAL:   if (tmr_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        wsel_en   = 1'b0;
        ssel      = 1'b0;
        pchg      = 1'b0;
        bus_oe    = 1'b0;
        vl        = VL_OFF;
        capture   = 1'b0;
        rsp_valid = 1'b0;
        phase_len = CNT_W'(1);
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_WSETUP: begin
                wsel_en   = 1'b1;
                bus_oe    = 1'b1;
                phase_len = CNT_W'(SETUP_CYC);
            end
            ST_WPULSE: begin
                wsel_en   = 1'b1;
                bus_oe    = 1'b1;
                vl        = VL_HALF;
                phase_len = CNT_W'(WR_CYC);
            end
            ST_WREL: ;
            ST_PCHG: begin
                pchg      = 1'b1;
                bus_oe    = 1'b1;
                phase_len = CNT_W'(PCHG_CYC);
            end
            ST_SSEL: begin
                ssel      = 1'b1;
                bus_oe    = 1'b1;
                phase_len = CNT_W'(SEL_CYC);
            end
            ST_EVAL: begin
                ssel      = 1'b1;
                bus_oe    = 1'b1;
                vl        = VL_FULL;
                capture   = tmr_done;
                phase_len = CNT_W'(RD_CYC);
            end
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R6
    AST_FULL_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vl == VL_FULL) |-> $past(ssel) && !$past(pchg)) else $error("full level before select"); // R4

endmodule

// File: rtl/rcam_datapath.sv
module rcam_datapath #(
    parameter int ROWS   = 8,
    parameter int WORD_W = 8,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [WORD_W-1:0] req_data,
    input  logic              wsel_en,
    input  logic              bus_oe,
    input  logic              capture,
    input  logic [ROWS-1:0]   ml_n,
    output logic [ROWS-1:0]   wsel,
    output logic [WORD_W-1:0] bus_d,
    output logic [ROWS-1:0]   match
);
    logic [ROW_W-1:0]  row_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            word_q <= '0;
        end else if (req_fire) begin
            row_q  <= req_row;
            word_q <= req_data;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign wsel[r] = wsel_en && (row_q == ROW_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       match[r] <= 1'b0;
            else if (capture) match[r] <= ~ml_n[r];
        end
    end

    assign bus_d = bus_oe ? word_q : '0;

endmodule

// File: rtl/rcam_seq.sv
module rcam_seq
    import rcam_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int WORD_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int WR_CYC    = 22,
    parameter int PCHG_CYC  = 2,
    parameter int SEL_CYC   = 1,
    parameter int RD_CYC    = 2,
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [WORD_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [ROWS-1:0]   rsp_match,
    output logic [ROWS-1:0]   wsel,
    output logic              ssel,
    output logic [1:0]        vl_lvl,
    output logic              pchg,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_d,
    input  logic [ROWS-1:0]   ml_n
);
    localparam int MAX_LEN = max_of(max_of(max_of(SETUP_CYC, WR_CYC),
                                           max_of(PCHG_CYC, SEL_CYC)), RD_CYC);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             tmr_restart;
    logic             tmr_done;
    logic [CNT_W-1:0] phase_len;
    logic             req_fire;
    logic             wsel_en;
    logic             capture;

    rcam_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (phase_len),
        .done    (tmr_done)
    );

    rcam_fsm #(
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .WR_CYC    (WR_CYC),
        .PCHG_CYC  (PCHG_CYC),
        .SEL_CYC   (SEL_CYC),
        .RD_CYC    (RD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_done    (tmr_done),
        .tmr_restart (tmr_restart),
        .phase_len   (phase_len),
        .req_fire    (req_fire),
        .ready       (req_ready),
        .wsel_en     (wsel_en),
        .ssel        (ssel),
        .pchg        (pchg),
        .bus_oe      (bus_oe),
        .vl          (vl_lvl),
        .capture     (capture),
        .rsp_valid   (rsp_valid)
    );

    rcam_datapath #(
        .ROWS   (ROWS),
        .WORD_W (WORD_W),
        .ROW_W  (ROW_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_fire (req_fire),
        .req_row  (req_row),
        .req_data (req_data),
        .wsel_en  (wsel_en),
        .bus_oe   (bus_oe),
        .capture  (capture),
        .ml_n     (ml_n),
        .wsel     (wsel),
        .bus_d    (bus_d),
        .match    (rsp_match)
    );

    AST_VL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vl_lvl != 2'b11) else $error("illegal VL code"); // R9
    AST_HALF_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_lvl == VL_HALF) |-> (wsel != '0)) else $error("half level without row"); // R9
    AST_FULL_NEEDS_SSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_lvl == VL_FULL) |-> ssel) else $error("full level without search select"); // R9
    AST_WSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wsel)) else $error("several rows selected"); // R2
    AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel != '0) |-> (!ssel && !pchg)) else $error("write and search overlap"); // R3
    AST_PCHG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pchg |-> (!ssel && vl_lvl == VL_OFF)) else $error("precharge during evaluation"); // R4
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (wsel == '0 && !ssel && !pchg && !bus_oe)) else $error("ready while busy"); // R7
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rsp_valid) && !rsp_valid |-> $stable(rsp_match)) else $error("match changed without response"); // R6

endmodule

// File: tb/sim_rcam_seq.sv
`timescale 1ns/1ps
module sim_rcam_seq;
    localparam int ROWS = 4, WORD_W = 4, ROW_W = 2;
    localparam int SETUP = 1, WR = 6, PC = 2, SL = 2, RD = 2;
    localparam int TS = PC + SL + RD;
    localparam int TW = SETUP + WR;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [WORD_W-1:0] req_data = '0;
    logic req_ready, rsp_valid, ssel, pchg, bus_oe;
    logic [ROWS-1:0] rsp_match, wsel, ml_n;
    logic [1:0] vl_lvl;
    logic [WORD_W-1:0] bus_d;

    logic [WORD_W-1:0] arr [ROWS];
    logic [WORD_W-1:0] exp_mem [ROWS];
    int checks = 0, failures = 0;
    int hold_row, hold_data;

    always #4 clk = ~clk;

    rcam_seq #(.ROWS(ROWS), .WORD_W(WORD_W), .SETUP_CYC(SETUP), .WR_CYC(WR),
               .PCHG_CYC(PC), .SEL_CYC(SL), .RD_CYC(RD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_match(rsp_match), .wsel(wsel), .ssel(ssel),
        .vl_lvl(vl_lvl), .pchg(pchg), .bus_oe(bus_oe), .bus_d(bus_d), .ml_n(ml_n));

    // behavioural array: half level stores bus into selected row; full level with
    // search select pulls matching rows low
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++)
            if (vl_lvl == 2'b01 && wsel[r] && bus_oe) arr[r] <= bus_d;
    end
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            ml_n[r] = !(ssel && vl_lvl == 2'b10 && bus_oe && arr[r] == bus_d);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic accept(input bit w, input int row, input int data);
        @(negedge clk);
        req_valid = 1'b1; req_write = w;
        req_row = ROW_W'(row); req_data = WORD_W'(data);
        chk(req_ready == 1'b1, "R7 ready before request", int'(req_ready), 1);
        @(posedge clk);
    endtask

    task automatic mon_write(input int row, input int data);
        int bad2 = 0, bad8 = 0, bad10 = 0, bad7 = 0, halfs = 0;
        for (int n = 1; n <= TW + 2; n++) begin
            @(negedge clk);
            if (n == 1) begin req_valid = 1'b0; req_data = ~WORD_W'(data); end
            if (n <= TW) begin
                if (wsel != ROWS'(1 << row) || ssel || pchg) bad2++;
                if (n <= SETUP && vl_lvl != 2'b00) bad2++;
                if (n > SETUP && vl_lvl != 2'b01) bad2++;
                if (vl_lvl == 2'b01) halfs++;
                if (!bus_oe || bus_d != WORD_W'(data)) bad10++;
            end else if (n == TW + 1) begin
                if (wsel != 0 || ssel || pchg || bus_oe || vl_lvl != 2'b00) bad8++;
            end
            if (n <= TW + 1 && req_ready) bad7++;
            if (n == TW + 2 && !req_ready) bad7++;
        end
        exp_mem[row] = WORD_W'(data);
        chk(bad2 == 0, "R2 write select phases", bad2, 0);
        chk(halfs == WR, "R2 half-level pulse length", halfs, WR);
        chk(bad8 == 0, "R8 rest cycle after write", bad8, 0);
        chk(bad10 == 0, "R10 write bus word", bad10, 0);
        chk(bad7 == 0, "R7 ready during write", bad7, 0);
    endtask

    task automatic mon_search(input int word, input bit hold);
        int bad3 = 0, bad4 = 0, bad6 = 0, bad7 = 0, bad8 = 0, bad10 = 0;
        logic [ROWS-1:0] expm = '0;
        for (int r = 0; r < ROWS; r++) if (exp_mem[r] == WORD_W'(word)) expm[r] = 1'b1;
        for (int n = 1; n <= TS + 2; n++) begin
            @(negedge clk);
            if (n == 1) begin
                if (hold) begin
                    req_valid = 1'b1; req_write = 1'b1;
                    req_row = ROW_W'(hold_row); req_data = WORD_W'(hold_data);
                end else begin
                    req_valid = 1'b0; req_data = ~WORD_W'(word);
                end
            end
            if (wsel != 0) bad3++;
            if (n <= PC) begin
                if (!pchg || ssel || vl_lvl != 2'b00) bad4++;
            end else if (n <= PC + SL) begin
                if (pchg || !ssel || vl_lvl != 2'b00) bad4++;
            end else if (n <= TS) begin
                if (pchg || !ssel || vl_lvl != 2'b10) bad4++;
            end
            if (n <= TS && (!bus_oe || bus_d != WORD_W'(word))) bad10++;
            if (n <= TS && rsp_valid) bad6++;
            if (n == TS + 1) begin
                if (!rsp_valid) bad6++;
                if (ssel || pchg || bus_oe || vl_lvl != 2'b00) bad8++;
                chk(rsp_match == expm, "R5 match vector", int'(rsp_match), int'(expm));
            end
            if (n == TS + 2) begin
                if (rsp_valid) bad6++;
                chk(rsp_match == expm, "R6 match held", int'(rsp_match), int'(expm));
            end
            if (n <= TS + 1 && req_ready) bad7++;
            if (n == TS + 2 && !req_ready) bad7++;
        end
        chk(bad3 == 0, "R3 no word select in search", bad3, 0);
        chk(bad4 == 0, "R4 search phase order", bad4, 0);
        chk(bad6 == 0, "R6 response timing", bad6, 0);
        chk(bad7 == 0, "R7 ready during search", bad7, 0);
        chk(bad8 == 0, "R8 rest cycle after search", bad8, 0);
        chk(bad10 == 0, "R10 search bus word", bad10, 0);
    endtask

    task automatic do_write(input int row, input int data);
        accept(1'b1, row, data);
        mon_write(row, data);
    endtask

    task automatic sweep();
        for (int w = 0; w < (1 << WORD_W); w++) begin
            accept(1'b0, 0, w);
            mon_search(w, 1'b0);
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin arr[r] = '1; exp_mem[r] = '1; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && rsp_match == 0 && wsel == 0 && !ssel && !pchg
            && !bus_oe && vl_lvl == 2'b00, "R1 reset outputs", int'(rsp_match), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // distinct words in every row
        for (int r = 0; r < ROWS; r++) do_write(r, (r * 5 + 3) % 16);
        sweep();
        // duplicates: rows 0 and 2 equal, rows 1 and 3 equal
        do_write(2, 3);
        do_write(3, 8);
        sweep();
        // zero and all-ones corner words
        do_write(0, 0);
        do_write(1, 15);
        sweep();

        // R7: write held valid during a search is taken exactly once
        hold_row = 2; hold_data = 9;
        accept(1'b0, 0, 15);
        mon_search(15, 1'b1);
        mon_write(2, 9);
        sweep();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule